// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block holds the arithmetic and logic step of a small 8-bit accumulator processor together with the four-bit flag register that goes with it. Each cycle a command selects what happens: a two-operand arithmetic or logic operation, one of three flag or accumulator utility actions, loading the flags from a packed 16-bit word, or nothing. The result byte, a write-back strobe and the next flag values leave the block combinationally in the same cycle. The flag register takes the new value on the next rising clock edge.

The stored carry is the carry input of the add-with-carry and subtract-with-borrow operations. Because of this, a chain of multi-byte arithmetic needs no extra wiring. The current flags, placed under the first operand, also appear as a 16-bit word, so the surrounding datapath can push the accumulator and flags as one pair. Loading such a word back restores the flags and returns its high byte as a result to write back.

The command decoder has these commands: IDLE (0), ARITH (1), FLIPC (2), SETC (3), INVA (4) and UNPACK (5). Codes 6 and 7 behave as IDLE. A command is a one-cycle transition of the flag register. The register takes the next flag value on the clock edge that ends the cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: When cmd_i is ARITH (1), op_i selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare. res_o is the 8-bit result of opnd_a_i combined with opnd_b_i.
- R2: Add with carry and subtract with borrow fold the stored carry flag into the right-hand operand. The other operations ignore the stored carry.
- R3: Half-carry is the carry out of bit 3 (addition) or the borrow into bit 4 (subtraction), computed from the low nibbles and the folded carry. AND forces half-carry to 1. OR and XOR clear it.
- R4: The subtract flag is 1 after subtract, subtract with borrow and compare, and 0 after every other ARITH operation.
- R5: Compare produces the same flags as subtract, but wr_en_o is 0.
- R6: Carry is the carry or borrow out of bit 7, or 0 for AND, OR and XOR. It is only written when upd_carry_i is 1. Otherwise the stored carry is kept.
- R7: After an ARITH command, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R8: FLIPC inverts carry and SETC sets carry to 1. Both clear subtract and half-carry, keep zero, and drive wr_en_o to 0.
- R9: INVA returns the bitwise inverse of opnd_a_i with wr_en_o = 1. It sets subtract and half-carry and keeps zero and carry.
- R10: af_word_o is opnd_a_i in bits 15:8 and the stored flags in bits 7:4 (zero bit 7, subtract bit 6, half-carry bit 5, carry bit 4). Bits 3:0 are 0.
- R11: UNPACK loads the flags from af_word_i bits 7:4, using the same bit positions as R10. It returns af_word_i bits 15:8 on res_o with wr_en_o = 1.
- R12: After reset all flags are 0. IDLE, and codes 6 and 7, leave the flags unchanged and drive wr_en_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| op_i | input | 3 | Arithmetic/logic operation code |
| opnd_a_i | input | 8 | Left operand (accumulator) |
| opnd_b_i | input | 8 | Right operand |
| upd_carry_i | input | 1 | Allow an ARITH command to write carry |
| af_word_i | input | 16 | Packed accumulator/flag word for UNPACK |
| res_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| flags_nxt_o | output | 4 | Next flags {zero, subtract, half, carry} |
| flags_q_o | output | 4 | Stored flags {zero, subtract, half, carry} |
| af_word_o | output | 16 | Packed accumulator/flag word |

## Verification
In one cycle the block both reads the stored carry, as the carry input of add-with-carry, subtract-with-borrow or FLIPC, and computes the carry that replaces it. The bench therefore issues back-to-back carry-consuming commands, some with upd_carry_i low, so each command depends on the carry the previous one left behind. A behavioural model tracks the flags from one cycle to the next and is compared with every output before each edge and with the stored flags after it. The packed output word is checked in the same cycles in which the flags change, so it must show the new flags exactly one edge after a command.

// File: rtl/alu_unit_pkg.sv
package alu_unit_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_ARITH  = 3'd1,
        CMD_FLIPC  = 3'd2,
        CMD_SETC   = 3'd3,
        CMD_INVA   = 3'd4,
        CMD_UNPACK = 3'd5
    } cmd_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_unit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_stored,
    input  logic              upd_carry,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output flags_t            f
);
    localparam int NIB = DATA_W / 2;

    logic              fold_c;
    logic [NIB:0]      lo_sum;
    logic [NIB:0]      lo_dif;
    logic [DATA_W:0]   full_sum;
    logic [DATA_W:0]   full_dif;
    logic              c_out;

    // Only the carry-consuming operations see the stored carry.
    assign fold_c = c_stored & ((op == OP_ADC) | (op == OP_SBC));

    assign lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, fold_c};
    assign lo_dif   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, fold_c};
    assign full_sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, fold_c};
    assign full_dif = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, fold_c};

    always_comb begin
        res   = '0;
        c_out = 1'b0;
        f.n   = 1'b0;
        f.h   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res   = full_sum[DATA_W-1:0];
                c_out = full_sum[DATA_W];
                f.h   = lo_sum[NIB];
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                res   = full_dif[DATA_W-1:0];
                c_out = full_dif[DATA_W];
                f.h   = lo_dif[NIB];
                f.n   = 1'b1;
            end
            OP_AND: begin
                res = a & b;
                f.h = 1'b1;
            end
            OP_XOR: res = a ^ b;
            OP_OR:  res = a | b;
            default: res = '0;
        endcase
        f.z = (res == '0);
        f.c = upd_carry ? c_out : c_stored;
        wr  = (op != OP_CMP);
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_unit_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_unit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd_i,
    input  logic [2:0]          op_i,
    input  logic [DATA_W-1:0]   opnd_a_i,
    input  logic [DATA_W-1:0]   opnd_b_i,
    input  logic                upd_carry_i,
    input  logic [2*DATA_W-1:0] af_word_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                wr_en_o,
    output logic [3:0]          flags_nxt_o,
    output logic [3:0]          flags_q_o,
    output logic [2*DATA_W-1:0] af_word_o
);
    localparam int PAD_W = DATA_W - FLAG_W;

    cmd_e              cmd;
    flags_t            fq;
    flags_t            fnxt;
    flags_t            core_f;
    logic [DATA_W-1:0] core_res;
    logic              core_wr;
    logic              load;

    assign cmd = cmd_e'(cmd_i);

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op        (alu_op_e'(op_i)),
        .a         (opnd_a_i),
        .b         (opnd_b_i),
        .c_stored  (fq.c),
        .upd_carry (upd_carry_i),
        .res       (core_res),
        .wr        (core_wr),
        .f         (core_f)
    );

    always_comb begin
        fnxt    = fq;
        res_o   = '0;
        wr_en_o = 1'b0;
        load    = 1'b1;
        case (cmd)
            CMD_ARITH: begin
                fnxt    = core_f;
                res_o   = core_res;
                wr_en_o = core_wr;
            end
            CMD_FLIPC: begin
                fnxt.c = ~fq.c;
                fnxt.n = 1'b0;
                fnxt.h = 1'b0;
            end
            CMD_SETC: begin
                fnxt.c = 1'b1;
                fnxt.n = 1'b0;
                fnxt.h = 1'b0;
            end
            CMD_INVA: begin
                res_o   = ~opnd_a_i;
                wr_en_o = 1'b1;
                fnxt.n  = 1'b1;
                fnxt.h  = 1'b1;
            end
            CMD_UNPACK: begin
                fnxt    = flags_t'(af_word_i[DATA_W-1 -: FLAG_W]);
                res_o   = af_word_i[2*DATA_W-1:DATA_W];
                wr_en_o = 1'b1;
            end
            default: load = 1'b0;
        endcase
    end

    flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (fnxt),
        .q     (fq)
    );

    assign flags_nxt_o = fnxt;
    assign flags_q_o   = fq;
    assign af_word_o   = {opnd_a_i, fq, {PAD_W{1'b0}}};

    // R5
    cmp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && op_i == 3'd7) |-> !wr_en_o);

    // R6
    carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && !upd_carry_i) |=> (flags_q_o[0] == $past(flags_q_o[0])));

    // R3
    and_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && op_i == 3'd4) |=> flags_q_o[1]);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1) |=> (flags_q_o[3] == ($past(res_o) == '0)));

    // R8
    flipc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd2) |=> (flags_q_o[0] != $past(flags_q_o[0])));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd0 || cmd_i[2:1] == 2'b11) |=> $stable(flags_q_o));
endmodule

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = 3'd0;
    logic [2:0]  op_i = 3'd0;
    logic [7:0]  opnd_a_i = 8'd0;
    logic [7:0]  opnd_b_i = 8'd0;
    logic        upd_carry_i = 1'b1;
    logic [15:0] af_word_i = 16'd0;
    logic [7:0]  res_o;
    logic        wr_en_o;
    logic [3:0]  flags_nxt_o;
    logic [3:0]  flags_q_o;
    logic [15:0] af_word_o;

    int checks = 0;
    int errors = 0;
    int mz = 0, mn = 0, mh = 0, mc = 0;  // model flags
    bit done = 0;

    always #10 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk, .rst_n, .cmd_i, .op_i, .opnd_a_i, .opnd_b_i, .upd_carry_i,
        .af_word_i, .res_o, .wr_en_o, .flags_nxt_o, .flags_q_o, .af_word_o
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int fl(input int z, input int n, input int h, input int c);
        return z * 8 + n * 4 + h * 2 + c;
    endfunction

    task automatic step(input string tag, input int cmd, input int op, input int a,
                        input int b, input int upd, input int word);
        int r, wr, z, n, h, c, cin, s;
        @(negedge clk);
        cmd_i = cmd[2:0]; op_i = op[2:0]; opnd_a_i = a[7:0]; opnd_b_i = b[7:0];
        upd_carry_i = upd[0]; af_word_i = word[15:0];
        r = 0; wr = 0; z = mz; n = mn; h = mh; c = mc;
        if (cmd == 1) begin
            cin = (op == 1 || op == 3) ? mc : 0;
            wr = (op != 7);
            if (op <= 1) begin
                s = a + b + cin; r = s % 256; n = 0;
                h = ((a % 16) + (b % 16) + cin) > 15 ? 1 : 0;
                if (upd != 0) c = (s > 255) ? 1 : 0;
            end else if (op == 2 || op == 3 || op == 7) begin
                s = a - b - cin; r = (s + 512) % 256; n = 1;
                h = ((a % 16) - (b % 16) - cin) < 0 ? 1 : 0;
                if (upd != 0) c = (s < 0) ? 1 : 0;
            end else begin
                r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
                n = 0; h = (op == 4) ? 1 : 0;
                if (upd != 0) c = 0;
            end
            z = (r == 0) ? 1 : 0;
        end else if (cmd == 2 || cmd == 3) begin
            c = (cmd == 2) ? 1 - mc : 1; n = 0; h = 0;
        end else if (cmd == 4) begin
            r = 255 - a; wr = 1; n = 1; h = 1;
        end else if (cmd == 5) begin
            r = (word / 256) % 256; wr = 1;
            z = (word >> 7) & 1; n = (word >> 6) & 1; h = (word >> 5) & 1; c = (word >> 4) & 1;
        end
        #5;
        cmp(tag, "res", res_o, r);
        cmp(tag, "wr_en", wr_en_o, wr);
        cmp(tag, "flags_nxt", flags_nxt_o, fl(z, n, h, c));
        cmp(tag, "af_word", af_word_o, a * 256 + fl(mz, mn, mh, mc) * 16);
        @(posedge clk);
        mz = z; mn = n; mh = h; mc = c;
        #1;
        cmp(tag, "flags_q", flags_q_o, fl(mz, mn, mh, mc));
    endtask

    initial begin
        #1;
        cmp("R12", "reset flags", flags_q_o, 0);
        cmp("R10", "reset word low", af_word_o[3:0], 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step("R3",  1, 0, 8'h0F, 8'h01, 1, 0);   // half-carry on add
        step("R6",  1, 0, 8'hF0, 8'h10, 1, 0);   // carry out, zero result
        step("R7",  1, 0, 8'h80, 8'h80, 1, 0);
        step("R2",  1, 1, 8'h00, 8'h00, 1, 0);   // adc folds stored carry
        step("R4",  1, 2, 8'h10, 8'h01, 1, 0);   // sub, half borrow
        step("R8",  3, 0, 8'h00, 8'h00, 1, 0);   // set carry
        step("R2",  1, 3, 8'h00, 8'h00, 1, 0);   // sbc with carry -> FF
        step("R2",  1, 3, 8'h05, 8'hFF, 1, 0);   // sbc rhs FF + carry
        step("R3",  1, 4, 8'hF0, 8'h0F, 1, 0);   // and forces half
        step("R6",  3, 0, 8'h00, 8'h00, 1, 0);
        step("R6",  1, 6, 8'h12, 8'h21, 1, 0);   // or clears carry
        step("R6",  3, 0, 8'h00, 8'h00, 1, 0);
        step("R6",  1, 0, 8'hFF, 8'h01, 0, 0);   // carry kept with update off
        step("R6",  1, 2, 8'h00, 8'h01, 0, 0);
        step("R5",  1, 7, 8'h42, 8'h42, 1, 0);   // compare: no write back
        step("R5",  1, 7, 8'h10, 8'h20, 1, 0);
        step("R1",  1, 5, 8'hAA, 8'hAA, 1, 0);
        step("R8",  2, 0, 8'h00, 8'h00, 1, 0);
        step("R8",  2, 0, 8'h00, 8'h00, 1, 0);
        step("R9",  4, 0, 8'h5A, 8'h00, 1, 0);
        step("R10", 0, 0, 8'hC3, 8'h00, 1, 0);
        step("R11", 5, 0, 8'h00, 8'h00, 1, 16'h7BAF);
        step("R11", 5, 0, 8'h00, 8'h00, 1, 16'h1150);
        step("R12", 6, 0, 8'h77, 8'h11, 1, 0);
        step("R12", 7, 2, 8'h00, 8'h00, 1, 0);
        for (int i = 0; i < 400; i++) begin
            int cm;
            cm = (i % 3 == 0) ? int'($urandom_range(0, 7)) : 1;
            step("R1", cm, int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
                 int'($urandom_range(0, 65535)));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule